// File: doc/BRIEF.md
# Coin-Credit Vending Controller

This block is the control core of a two-product vending machine. It accepts nickel and dime pulses and keeps the customer's running credit. It serves a candy or soda request when the matching button is pressed and enough money has been paid in. Credit is held as a count of 5-cent steps and is capped at 15 cents. Money paid beyond the cap is kept by the machine. Candy costs 10 cents and soda costs 15 cents.

The two dispense outputs are Mealy outputs. Each goes high combinationally in the same cycle as its button press when the credit already held is enough. The price is taken off the credit at the next clock edge. The credit value in cents is shown on a 4-bit unsigned output. Reset is synchronous.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the credit is 0 after that edge. Both `candy_out_o` and `soda_out_o` are low for as long as `rst` is high.
- R2: `credit_o` only ever shows 0, 5, 10 or 15.
- R3: A cycle with `nickel_i` high adds 5 to the credit at the next edge, saturating at 15.
- R4: A cycle with `dime_i` high adds 10 to the credit at the next edge, saturating at 15. A dime at 10 or 15 therefore leaves 15.
- R5: When `candy_btn_i` is high and the credit is at least 10, `candy_out_o` is high in that same cycle, and the credit is 10 lower after the next edge.
- R6: When `soda_btn_i` is high and the credit is 15, `soda_out_o` is high in that same cycle, and the credit is 0 after the next edge.
- R7: A button press without enough credit leaves both dispense outputs low and the credit unchanged. This covers candy below 10, and soda below 15.
- R8: A cycle with no input asserted leaves the credit unchanged, and both dispense outputs stay low in any cycle without their own button.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dime_i | input | 1 | One-cycle pulse: a dime was inserted |
| nickel_i | input | 1 | One-cycle pulse: a nickel was inserted |
| candy_btn_i | input | 1 | Candy request button |
| soda_btn_i | input | 1 | Soda request button |
| candy_out_o | output | 1 | Dispense candy (Mealy, same cycle as request) |
| soda_out_o | output | 1 | Dispense soda (Mealy, same cycle as request) |
| credit_o | output | 4 | Current credit in cents |

## Verification
The assertions rely on the four event inputs being mutually exclusive in every cycle outside reset. A separate property watches that condition, so a stimulus that breaks it is flagged rather than masking a real fault. The directed tasks drive at most one input per cycle and change inputs only on the falling clock edge. As a result, each Mealy output is sampled with a stable request, and each credit update is seen one full edge later.

// File: rtl/vend_pkg.sv
package vend_pkg;

  // Decoded request for one cycle; inputs are expected one-hot.
  typedef enum logic [2:0] {
    ACT_IDLE   = 3'd0,
    ACT_NICKEL = 3'd1,
    ACT_DIME   = 3'd2,
    ACT_CANDY  = 3'd3,
    ACT_SODA   = 3'd4
  } vend_act_e;

  // Add with a ceiling, in credit steps.
  function automatic int unsigned step_sat_add(int unsigned cur, int unsigned add,
                                               int unsigned cap);
    int unsigned sum;
    sum = cur + add;
    return (sum > cap) ? cap : sum;
  endfunction

  // True when an add would have exceeded the ceiling.
  function automatic logic step_clips(int unsigned cur, int unsigned add,
                                      int unsigned cap);
    return (cur + add) > cap;
  endfunction

  // Convert a step count to cents.
  function automatic int unsigned steps_to_cents(int unsigned steps, int unsigned step_cents);
    return steps * step_cents;
  endfunction

endpackage

// File: rtl/vend_event_decode.sv
module vend_event_decode
  import vend_pkg::*;
(
  input  logic      dime_i,
  input  logic      nickel_i,
  input  logic      candy_btn_i,
  input  logic      soda_btn_i,
  output vend_act_e act_o
);

  // Buttons take precedence over coins if the one-hot rule is broken.
  always_comb begin
    if (candy_btn_i)     act_o = ACT_CANDY;
    else if (soda_btn_i) act_o = ACT_SODA;
    else if (dime_i)     act_o = ACT_DIME;
    else if (nickel_i)   act_o = ACT_NICKEL;
    else                 act_o = ACT_IDLE;
  end

endmodule

// File: rtl/vend_dispense.sv
module vend_dispense
  import vend_pkg::*;
#(
  parameter int unsigned UNIT_W      = 2,
  parameter int unsigned CANDY_UNITS = 2,
  parameter int unsigned SODA_UNITS  = 3
) (
  input  logic              hold_i,
  input  vend_act_e         act_i,
  input  logic [UNIT_W-1:0] units_i,
  output logic              candy_go_o,
  output logic              soda_go_o,
  output logic              refused_o
);

  localparam logic [UNIT_W-1:0] CANDY_PRICE = UNIT_W'(CANDY_UNITS);
  localparam logic [UNIT_W-1:0] SODA_PRICE  = UNIT_W'(SODA_UNITS);

  logic candy_ok;
  logic soda_ok;

  assign candy_ok = (units_i >= CANDY_PRICE);
  assign soda_ok  = (units_i >= SODA_PRICE);

  always_comb begin
    candy_go_o = 1'b0;
    soda_go_o  = 1'b0;
    refused_o  = 1'b0;
    if (!hold_i) begin
      unique case (act_i)
        ACT_CANDY: begin
          candy_go_o = candy_ok;
          refused_o  = !candy_ok;
        end
        ACT_SODA: begin
          soda_go_o = soda_ok;
          refused_o = !soda_ok;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vend_credit_next.sv
module vend_credit_next
  import vend_pkg::*;
#(
  parameter int unsigned UNIT_W       = 2,
  parameter int unsigned CAP_UNITS    = 3,
  parameter int unsigned NICKEL_UNITS = 1,
  parameter int unsigned DIME_UNITS   = 2,
  parameter int unsigned CANDY_UNITS  = 2,
  parameter int unsigned SODA_UNITS   = 3
) (
  input  logic              rst,
  input  vend_act_e         act_i,
  input  logic [UNIT_W-1:0] units_i,
  input  logic              candy_go_i,
  input  logic              soda_go_i,
  output logic [UNIT_W-1:0] units_nxt_o,
  output logic              clipped_o
);

  always_comb begin
    units_nxt_o = units_i;
    clipped_o   = 1'b0;
    if (rst) begin
      units_nxt_o = '0;
    end else if (candy_go_i) begin
      units_nxt_o = units_i - UNIT_W'(CANDY_UNITS);
    end else if (soda_go_i) begin
      units_nxt_o = units_i - UNIT_W'(SODA_UNITS);
    end else begin
      unique case (act_i)
        ACT_NICKEL: begin
          units_nxt_o = UNIT_W'(step_sat_add(int'(units_i), NICKEL_UNITS, CAP_UNITS));
          clipped_o   = step_clips(int'(units_i), NICKEL_UNITS, CAP_UNITS);
        end
        ACT_DIME: begin
          units_nxt_o = UNIT_W'(step_sat_add(int'(units_i), DIME_UNITS, CAP_UNITS));
          clipped_o   = step_clips(int'(units_i), DIME_UNITS, CAP_UNITS);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int unsigned STEP_CENTS   = 5,
  parameter int unsigned CAP_UNITS    = 3,
  parameter int unsigned NICKEL_UNITS = 1,
  parameter int unsigned DIME_UNITS   = 2,
  parameter int unsigned CANDY_UNITS  = 2,
  parameter int unsigned SODA_UNITS   = 3,
  parameter int unsigned CR_W         = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dime_i,
  input  logic            nickel_i,
  input  logic            candy_btn_i,
  input  logic            soda_btn_i,
  output logic            candy_out_o,
  output logic            soda_out_o,
  output logic [CR_W-1:0] credit_o
);

  localparam int unsigned UNIT_W = (CAP_UNITS < 2) ? 1 : $clog2(CAP_UNITS + 1);

  vend_act_e         act;
  logic [UNIT_W-1:0] units_q;
  logic [UNIT_W-1:0] units_nxt;
  logic              candy_go;
  logic              soda_go;
  logic              refused;     // event: button pressed without enough credit
  logic              coin_clip;   // event: coin value partly lost at the cap

  vend_event_decode u_decode (
    .dime_i      (dime_i),
    .nickel_i    (nickel_i),
    .candy_btn_i (candy_btn_i),
    .soda_btn_i  (soda_btn_i),
    .act_o       (act)
  );

  vend_dispense #(
    .UNIT_W      (UNIT_W),
    .CANDY_UNITS (CANDY_UNITS),
    .SODA_UNITS  (SODA_UNITS)
  ) u_dispense (
    .hold_i     (rst),
    .act_i      (act),
    .units_i    (units_q),
    .candy_go_o (candy_go),
    .soda_go_o  (soda_go),
    .refused_o  (refused)
  );

  vend_credit_next #(
    .UNIT_W       (UNIT_W),
    .CAP_UNITS    (CAP_UNITS),
    .NICKEL_UNITS (NICKEL_UNITS),
    .DIME_UNITS   (DIME_UNITS),
    .CANDY_UNITS  (CANDY_UNITS),
    .SODA_UNITS   (SODA_UNITS)
  ) u_next (
    .rst         (rst),
    .act_i       (act),
    .units_i     (units_q),
    .candy_go_i  (candy_go),
    .soda_go_i   (soda_go),
    .units_nxt_o (units_nxt),
    .clipped_o   (coin_clip)
  );

  always_ff @(posedge clk) begin
    units_q <= units_nxt;
  end

  assign candy_out_o = candy_go;
  assign soda_out_o  = soda_go;
  assign credit_o    = CR_W'(steps_to_cents(int'(units_q), STEP_CENTS));

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
  parameter int unsigned STEP_CENTS   = 5,
  parameter int unsigned CAP_UNITS    = 3,
  parameter int unsigned NICKEL_UNITS = 1,
  parameter int unsigned DIME_UNITS   = 2,
  parameter int unsigned CANDY_UNITS  = 2,
  parameter int unsigned SODA_UNITS   = 3,
  parameter int unsigned CR_W         = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            dime_i,
  input logic            nickel_i,
  input logic            candy_btn_i,
  input logic            soda_btn_i,
  input logic            candy_out_o,
  input logic            soda_out_o,
  input logic [CR_W-1:0] credit_o,
  input logic            refused,
  input logic            coin_clip
);

  localparam logic [CR_W-1:0] CAP_C   = CR_W'(CAP_UNITS * STEP_CENTS);
  localparam logic [CR_W-1:0] NICK_C  = CR_W'(NICKEL_UNITS * STEP_CENTS);
  localparam logic [CR_W-1:0] DIME_C  = CR_W'(DIME_UNITS * STEP_CENTS);
  localparam logic [CR_W-1:0] CANDY_C = CR_W'(CANDY_UNITS * STEP_CENTS);
  localparam logic [CR_W-1:0] SODA_C  = CR_W'(SODA_UNITS * STEP_CENTS);

  // Input assumption: request pulses never overlap.
  onehot_inputs_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dime_i, nickel_i, candy_btn_i, soda_btn_i}));

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> credit_o == '0);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |-> !candy_out_o && !soda_out_o);

  // R2
  credit_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (credit_o <= CAP_C) && ((credit_o % CR_W'(STEP_CENTS)) == '0));

  // R3
  nickel_add_chk: assert property (@(posedge clk) disable iff (rst)
    nickel_i |=> credit_o == (($past(credit_o) >= CAP_C - NICK_C) ? CAP_C
                                                                  : $past(credit_o) + NICK_C));

  // R4
  dime_add_chk: assert property (@(posedge clk) disable iff (rst)
    dime_i |=> credit_o == (($past(credit_o) >= CAP_C - DIME_C) ? CAP_C
                                                                : $past(credit_o) + DIME_C));

  // R3
  clip_lands_at_cap_chk: assert property (@(posedge clk) disable iff (rst)
    coin_clip |=> credit_o == CAP_C);

  // R5
  candy_needs_credit_chk: assert property (@(posedge clk) disable iff (rst)
    candy_out_o |-> candy_btn_i && credit_o >= CANDY_C);
  // R5
  candy_debit_chk: assert property (@(posedge clk) disable iff (rst)
    candy_out_o |=> credit_o == $past(credit_o) - CANDY_C);

  // R6
  soda_needs_credit_chk: assert property (@(posedge clk) disable iff (rst)
    soda_out_o |-> soda_btn_i && credit_o >= SODA_C);
  // R6
  soda_clears_chk: assert property (@(posedge clk) disable iff (rst)
    soda_out_o |=> credit_o == '0);

  // R7
  refused_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    refused |-> !candy_out_o && !soda_out_o);
  // R7
  refused_hold_chk: assert property (@(posedge clk) disable iff (rst)
    refused |=> $stable(credit_o));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(dime_i || nickel_i || candy_btn_i || soda_btn_i) |=> $stable(credit_o));

endmodule

bind vend_ctrl vend_ctrl_chk #(
  .STEP_CENTS   (STEP_CENTS),
  .CAP_UNITS    (CAP_UNITS),
  .NICKEL_UNITS (NICKEL_UNITS),
  .DIME_UNITS   (DIME_UNITS),
  .CANDY_UNITS  (CANDY_UNITS),
  .SODA_UNITS   (SODA_UNITS),
  .CR_W         (CR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dime_i      (dime_i),
  .nickel_i    (nickel_i),
  .candy_btn_i (candy_btn_i),
  .soda_btn_i  (soda_btn_i),
  .candy_out_o (candy_out_o),
  .soda_out_o  (soda_out_o),
  .credit_o    (credit_o),
  .refused     (refused),
  .coin_clip   (coin_clip)
);

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dime = 1'b0, nickel = 1'b0, candy = 1'b0, soda = 1'b0;
  logic       candy_out, soda_out;
  logic [3:0] credit;

  int checks = 0;
  int fails  = 0;
  int model  = 0;      // expected credit in cents
  bit done   = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  vend_ctrl dut (
    .clk         (clk),
    .rst         (rst),
    .dime_i      (dime),
    .nickel_i    (nickel),
    .candy_btn_i (candy),
    .soda_btn_i  (soda),
    .candy_out_o (candy_out),
    .soda_out_o  (soda_out),
    .credit_o    (credit)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive on the falling edge, sample Mealy outputs, then credit after the edge.
  task automatic step(input string req, input bit d, input bit n, input bit c, input bit s);
    int exp_c, exp_s;
    @(negedge clk);
    dime = d; nickel = n; candy = c; soda = s;
    exp_c = (c && model >= 10) ? 1 : 0;
    exp_s = (s && model == 15) ? 1 : 0;
    #1;
    check(req, "candy_out", int'(candy_out), exp_c);
    check(req, "soda_out",  int'(soda_out),  exp_s);
    if (exp_c == 1)      model = model - 10;
    else if (exp_s == 1) model = 0;
    else if (d)          model = (model + 10 > 15) ? 15 : model + 10;
    else if (n)          model = (model + 5 > 15) ? 15 : model + 5;
    @(posedge clk);
    #1;
    check(req, "credit", int'(credit), model);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; dime = 0; nickel = 0; candy = 0; soda = 0;
    @(posedge clk); #1;
    model = 0;
    check("R1", "credit after reset", int'(credit), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    step("R8", 0, 0, 0, 0);
  endtask

  task automatic t_nickels();
    do_reset();
    step("R3", 0, 1, 0, 0);   // 5
    step("R3", 0, 1, 0, 0);   // 10
    step("R3", 0, 1, 0, 0);   // 15
    step("R3", 0, 1, 0, 0);   // stays 15
    check("R3", "saturated nickel", int'(credit), 15);
  endtask

  task automatic t_dimes();
    do_reset();
    step("R4", 1, 0, 0, 0);   // 10
    step("R4", 1, 0, 0, 0);   // 15, 5 lost
    check("R4", "dime at 10", int'(credit), 15);
    step("R4", 1, 0, 0, 0);   // 15
    do_reset();
    step("R4", 0, 1, 0, 0);   // 5
    step("R4", 1, 0, 0, 0);   // 15
  endtask

  task automatic t_candy();
    do_reset();
    step("R5", 1, 0, 0, 0);   // 10
    step("R5", 0, 0, 1, 0);   // dispense, 0
    check("R5", "candy from 10", int'(credit), 0);
    step("R3", 0, 1, 0, 0);   // 5
    step("R4", 1, 0, 0, 0);   // 15
    step("R5", 0, 0, 1, 0);   // dispense, 5
    check("R5", "candy from 15", int'(credit), 5);
  endtask

  task automatic t_soda();
    do_reset();
    step("R6", 1, 0, 0, 0);
    step("R6", 0, 1, 0, 0);   // 15
    step("R6", 0, 0, 0, 1);   // dispense, 0
    check("R6", "soda clears", int'(credit), 0);
  endtask

  task automatic t_short();
    do_reset();
    step("R7", 0, 0, 1, 0);   // candy at 0
    step("R7", 0, 0, 0, 1);   // soda at 0
    step("R7", 0, 1, 0, 0);   // 5
    step("R7", 0, 0, 1, 0);   // candy at 5 refused
    check("R7", "credit kept at 5", int'(credit), 5);
    step("R7", 0, 1, 0, 0);   // 10
    step("R7", 0, 0, 0, 1);   // soda at 10 refused
    check("R7", "credit kept at 10", int'(credit), 10);
  endtask

  task automatic t_idle_and_reset_gate();
    do_reset();
    step("R8", 1, 0, 0, 0);
    step("R8", 0, 1, 0, 0);   // 15
    step("R8", 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0);
    check("R8", "idle hold", int'(credit), 15);
    // Reset with a funded request pending: outputs stay low.
    @(negedge clk);
    rst = 1'b1; soda = 1'b1;
    #1;
    check("R1", "soda_out in reset", int'(soda_out), 0);
    @(posedge clk); #1;
    check("R1", "credit after reset with soda", int'(credit), 0);
    @(negedge clk);
    rst = 1'b0; soda = 1'b0;
    model = 0;
    step("R1", 0, 0, 0, 1);   // soda at 0 refused
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset_state();
    t_nickels();
    t_dimes();
    t_candy();
    t_soda();
    t_short();
    t_idle_and_reset_gate();
    summary();
  end

endmodule